// File: doc/BRIEF.md
# Power-management register block

This block is a small register file of power-management state that software reaches over a simple I/O port bus. Each access carries a byte offset, a byte count and a read or write strobe. An access may land on any byte inside a register. The data is then shifted by that byte's distance from the register's base, and a write changes only the byte lanes that the access covers. The block holds event status, event enables, sleep control, processor control, global enable and control, device status and control, and a 32-bit general-purpose output register.

The block merges pending events into one level-sensitive system control interrupt. Sixteen external event lines are captured on their rising edges into a general-purpose status word. A write to the sleep control field, or the magic value written to the reset register, produces a single-cycle request pulse for power-off, hibernate or reboot. A free-running 32-bit timer advances at 3.579545 MHz. It is derived from the system clock by a fractional accumulator, and its overflow sets status bit 0.

Top module: `pm_regblock`

## Requirements
- R1: After reset the general-purpose output register reads 0x7FFFBFFF and every other register reads 0, except that control bit 0 is set one cycle after reset when acpi_mode_i is high. Offsets 0x06, 0x14, 0x30 and all other offsets outside the register map read 0.
- R2: Read data is registered and appears in the cycle after rd_i. It holds size_i bytes (1, 2 or 4), taken from the register starting at the addressed byte, and the upper bytes are 0. A write at base+k shifts wdata_i left by k bytes and changes only the covered lanes of that one register.
- R3: Writing 1s to status (0x00) or to GP status (0x0C) clears those bits, and bits written as 0 are kept. When a set and a clear hit the same bit in the same cycle, the set wins.
- R4: Only these bits are writable, and all others stay 0: resume enable (0x02) 0x0521, GP enable (0x0E) 0x0F01, processor control (0x10) 0x00023E1E, global enable (0x20) 0x8D13. Control (0x04) and device control (0x2C) are fully writable.
- R5: Global control (0x28) writes only the bits in 0x0701FFE5, so bit 1 always stays 0. Bit 31 of the general-purpose output register (0x34..0x37) never becomes 1.
- R6: A write to control with bit 13 of the shifted data set decodes bits 12:10. A value of 0 gives a one-cycle pulse on power_off_o and a value of 1 gives one on hibernate_o, in the cycle after the write. Any other value gives no pulse. The data is stored in either case.
- R7: Writing 0x01 to the byte at 0x33 gives a one-cycle pulse on reboot_o in the cycle after the write. Any other value does nothing.
- R8: Global status (0x18) reads bit 7 when GP status is nonzero, bit 6 when any status bit except bit 0 is set, and bit 4 when device status is nonzero. Its other bits read 0.
- R9: sci_o is high exactly when (resume enable ≠ 0 and status ≠ 0) or (GP status ≠ 0 and GP enable ≠ 0). It follows any change one cycle after the change.
- R10: A rising edge on event_i[n] sets GP status bit n. A line that is held high does not set the bit again after it has been cleared.
- R11: The timer (0x08, 4 bytes) counts at TICK_HZ/CLK_HZ counts per clock with no long-term error, and writes to it are ignored. Each toggle of timer bit OVF_BIT sets status bit 0.
- R12: A write to device status (0x1C) stores the bitwise complement of the shifted, lane-masked write data in all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| acpi_mode_i | input | 1 | sets control bit 0 after reset |
| addr_i | input | ADDR_W | byte offset of the access |
| size_i | input | 3 | access size in bytes (1, 2 or 4) |
| wr_i | input | 1 | write strobe |
| rd_i | input | 1 | read strobe |
| wdata_i | input | 32 | write data, byte lane 0 in bits 7:0 |
| rdata_o | output | 32 | registered read data |
| event_i | input | 16 | external event lines |
| sci_o | output | 1 | system control interrupt level |
| power_off_o | output | 1 | power-off request pulse |
| hibernate_o | output | 1 | hibernate request pulse |
| reboot_o | output | 1 | reboot request pulse |

## Verification
The register accesses mix full-width, half-width and single-byte operations at base and non-base offsets. This tells correct lane shifting apart from data that is written to the wrong lane or that spills into a neighbour. Writes of all-ones to each masked register expose a wrong writable mask. Sleep-control values with type 0, type 1 and another type, sent both as word writes and as byte writes, separate the decode from the lane shift. Event lines are raised, held, cleared and raised again to check edge detection against level detection. A long idle run checks the timer's exact rate and the overflow path into status.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int DATA_W = 32;
  localparam int EV_N   = 16;

  typedef enum logic [3:0] {
    R_NONE, R_STS, R_REN, R_CTL, R_TMR, R_GPS, R_GPE, R_PRC,
    R_GST, R_DST, R_GEN, R_GCT, R_DCT, R_RST, R_GPO
  } reg_id_e;

  typedef struct packed {
    reg_id_e    id;
    logic [1:0] sh;
  } dec_t;

  localparam logic [15:0] REN_WM  = 16'h0521;
  localparam logic [15:0] GPE_WM  = 16'h0F01;
  localparam logic [15:0] GEN_WM  = 16'h8D13;
  localparam logic [31:0] PRC_WM  = 32'h0002_3E1E;
  localparam logic [31:0] GCT_WM  = 32'h0701_FFE5;
  localparam logic [31:0] GPO_WM  = 32'h7FFF_FFFF;
  localparam logic [31:0] GPO_RST = 32'h7FFF_BFFF;
  localparam logic [7:0]  RST_KEY = 8'h01;
  localparam int          SLP_EN  = 13;
  localparam int          SLP_LSB = 10;

  function automatic dec_t decode(input logic [5:0] a);
    dec_t d;
    d.id = R_NONE;
    d.sh = a[1:0];
    case (a[5:2])
      4'd0:  begin d.id = a[1] ? R_REN : R_STS; d.sh = {1'b0, a[0]}; end
      4'd1:  begin d.id = a[1] ? R_NONE : R_CTL; d.sh = {1'b0, a[0]}; end
      4'd2:  d.id = R_TMR;
      4'd3:  begin d.id = a[1] ? R_GPE : R_GPS; d.sh = {1'b0, a[0]}; end
      4'd4:  d.id = R_PRC;
      4'd6:  begin d.id = a[1] ? R_NONE : R_GST; d.sh = {1'b0, a[0]}; end
      4'd7:  d.id = R_DST;
      4'd8:  begin d.id = a[1] ? R_NONE : R_GEN; d.sh = {1'b0, a[0]}; end
      4'd10: d.id = R_GCT;
      4'd11: d.id = R_DCT;
      4'd12: begin d.id = (a[1:0] == 2'd3) ? R_RST : R_NONE; d.sh = 2'd0; end
      4'd13: d.id = R_GPO;
      default: d.id = R_NONE;
    endcase
    return d;
  endfunction

  function automatic logic [3:0] size_lanes(input logic [2:0] sz);
    case (sz)
      3'd0:    return 4'b0000;
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 3_579_545,
  parameter int CNT_W   = 32,
  parameter int OVF_BIT = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int ACC_W = $clog2(CLK_HZ) + 1;
  localparam logic [ACC_W:0] STEP = (ACC_W+1)'(TICK_HZ);
  localparam logic [ACC_W:0] LIM  = (ACC_W+1)'(CLK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum, rem;
  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign sum   = {1'b0, acc_q} + STEP;
  assign tick  = (sum >= LIM);
  assign rem   = tick ? (sum - LIM) : sum;
  assign cnt_d = cnt_q + CNT_W'(tick);
  assign ovf_o = tick && (cnt_d[OVF_BIT] != cnt_q[OVF_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= rem[ACC_W-1:0];
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pm_edge_latch.sv
module pm_edge_latch #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] ev_q_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= ev_i;
  end

  assign rise_o = ev_i & ~ev_q;
  assign ev_q_o = ev_q;
endmodule

// File: rtl/pm_reg_file.sv
module pm_reg_file
  import pm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_set_i,
  input  logic              we_i,
  input  reg_id_e           id_i,
  input  logic [1:0]        sh_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tmr_ovf_i,
  input  logic [EV_N-1:0]   gps_set_i,
  output logic [15:0]       sts_o,
  output logic [15:0]       ren_o,
  output logic [15:0]       ctl_o,
  output logic [15:0]       gps_o,
  output logic [15:0]       gpe_o,
  output logic [15:0]       gen_o,
  output logic [31:0]       prc_o,
  output logic [31:0]       dst_o,
  output logic [31:0]       gct_o,
  output logic [31:0]       dct_o,
  output logic [31:0]       gpo_o,
  output logic              poff_o,
  output logic              hib_o,
  output logic              rbt_o
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0]     lanes;
  logic [DATA_W-1:0] bm, wv;
  logic              init_q;

  logic [15:0] sts_q, ren_q, ctl_q, gps_q, gpe_q, gen_q;
  logic [31:0] prc_q, dst_q, gct_q, dct_q, gpo_q;
  logic [15:0] sts_d, ren_d, ctl_d, gps_d, gpe_d, gen_d;
  logic [31:0] prc_d, dst_d, gct_d, dct_d, gpo_d;
  logic        poff_d, hib_d, rbt_d, poff_q, hib_q, rbt_q;
  logic [2:0]  slp_typ;

  assign lanes = size_lanes(size_i) << sh_i;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign bm[8*i +: 8] = {8{lanes[i]}};
  end

  assign wv      = (wdata_i << {sh_i, 3'b000}) & bm;
  assign slp_typ = wv[SLP_LSB +: 3];

  always_comb begin
    sts_d = sts_q; ren_d = ren_q; ctl_d = ctl_q; gps_d = gps_q;
    gpe_d = gpe_q; gen_d = gen_q; prc_d = prc_q; dst_d = dst_q;
    gct_d = gct_q; dct_d = dct_q; gpo_d = gpo_q;
    poff_d = 1'b0; hib_d = 1'b0; rbt_d = 1'b0;
    if (we_i) begin
      case (id_i)
        R_STS: sts_d = sts_q & ~wv[15:0];
        R_REN: ren_d = (ren_q & ~bm[15:0]) | (wv[15:0] & REN_WM);
        R_CTL: begin
          ctl_d = (ctl_q & ~bm[15:0]) | wv[15:0];
          if (wv[SLP_EN]) begin
            poff_d = (slp_typ == 3'd0);
            hib_d  = (slp_typ == 3'd1);
          end
        end
        R_GPS: gps_d = gps_q & ~wv[15:0];
        R_GPE: gpe_d = (gpe_q & ~bm[15:0]) | (wv[15:0] & GPE_WM);
        R_PRC: prc_d = (prc_q & ~bm) | (wv & PRC_WM);
        R_DST: dst_d = ~wv;
        R_GEN: gen_d = (gen_q & ~bm[15:0]) | (wv[15:0] & GEN_WM);
        R_GCT: gct_d = (gct_q & ~bm) | (wv & GCT_WM);
        R_DCT: dct_d = (dct_q & ~bm) | wv;
        R_RST: rbt_d = lanes[0] && (wdata_i[7:0] == RST_KEY);
        R_GPO: gpo_d = (gpo_q & ~bm) | (wv & GPO_WM);
        default: ;
      endcase
    end
    // event sets override same-cycle clears
    if (tmr_ovf_i) sts_d[0] = 1'b1;
    gps_d = gps_d | gps_set_i;
    if (init_q && init_set_i) ctl_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0; ren_q <= '0; ctl_q <= '0; gps_q <= '0; gpe_q <= '0;
      gen_q <= '0; prc_q <= '0; dst_q <= '0; gct_q <= '0; dct_q <= '0;
      gpo_q <= GPO_RST; init_q <= 1'b1;
      poff_q <= 1'b0; hib_q <= 1'b0; rbt_q <= 1'b0;
    end else begin
      sts_q <= sts_d; ren_q <= ren_d; ctl_q <= ctl_d; gps_q <= gps_d;
      gpe_q <= gpe_d; gen_q <= gen_d; prc_q <= prc_d; dst_q <= dst_d;
      gct_q <= gct_d; dct_q <= dct_d; gpo_q <= gpo_d; init_q <= 1'b0;
      poff_q <= poff_d; hib_q <= hib_d; rbt_q <= rbt_d;
    end
  end

  assign sts_o = sts_q; assign ren_o = ren_q; assign ctl_o = ctl_q;
  assign gps_o = gps_q; assign gpe_o = gpe_q; assign gen_o = gen_q;
  assign prc_o = prc_q; assign dst_o = dst_q; assign gct_o = gct_q;
  assign dct_o = dct_q; assign gpo_o = gpo_q;
  assign poff_o = poff_q; assign hib_o = hib_q; assign rbt_o = rbt_q;
endmodule

// File: rtl/pm_regblock.sv
module pm_regblock
  import pm_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 3_579_545,
  parameter int OVF_BIT = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acpi_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EV_N-1:0]   event_i,
  output logic              sci_o,
  output logic              power_off_o,
  output logic              hibernate_o,
  output logic              reboot_o
);
  localparam int NB = DATA_W / 8;
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(56);

  dec_t              dec;
  reg_id_e           id;
  logic [3:0]        szl;
  logic [EV_N-1:0]   ev_q, ev_rise;
  logic [31:0]       tmr_cnt;
  logic              tmr_ovf;
  logic [15:0]       sts_q, ren_q, ctl_q, gps_q, gpe_q, gen_q, gst_v;
  logic [31:0]       prc_q, dst_q, gct_q, dct_q, gpo_q;
  logic [DATA_W-1:0] full_v, shf_v, rd_v, rdata_q;

  assign dec = decode(addr_i[5:0]);
  assign id  = (addr_i < MAP_END) ? dec.id : R_NONE;
  assign szl = size_lanes(size_i);

  pm_tick_gen #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(32), .OVF_BIT(OVF_BIT)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_o(tmr_cnt), .ovf_o(tmr_ovf)
  );

  pm_edge_latch #(.N(EV_N)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(event_i), .ev_q_o(ev_q), .rise_o(ev_rise)
  );

  pm_reg_file u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_set_i(acpi_mode_i),
    .we_i(wr_i), .id_i(id), .sh_i(dec.sh), .size_i(size_i), .wdata_i(wdata_i),
    .tmr_ovf_i(tmr_ovf), .gps_set_i(ev_rise),
    .sts_o(sts_q), .ren_o(ren_q), .ctl_o(ctl_q), .gps_o(gps_q), .gpe_o(gpe_q),
    .gen_o(gen_q), .prc_o(prc_q), .dst_o(dst_q), .gct_o(gct_q), .dct_o(dct_q),
    .gpo_o(gpo_q), .poff_o(power_off_o), .hib_o(hibernate_o), .rbt_o(reboot_o)
  );

  always_comb begin
    gst_v    = '0;
    gst_v[7] = |gps_q;
    gst_v[6] = |sts_q[15:1];
    gst_v[4] = |dst_q;
  end

  always_comb begin
    case (id)
      R_STS:   full_v = {16'h0, sts_q};
      R_REN:   full_v = {16'h0, ren_q};
      R_CTL:   full_v = {16'h0, ctl_q};
      R_TMR:   full_v = tmr_cnt;
      R_GPS:   full_v = {16'h0, gps_q};
      R_GPE:   full_v = {16'h0, gpe_q};
      R_PRC:   full_v = prc_q;
      R_GST:   full_v = {16'h0, gst_v};
      R_DST:   full_v = dst_q;
      R_GEN:   full_v = {16'h0, gen_q};
      R_GCT:   full_v = gct_q;
      R_DCT:   full_v = dct_q;
      R_GPO:   full_v = gpo_q;
      default: full_v = '0;
    endcase
  end

  assign shf_v = full_v >> {dec.sh, 3'b000};

  for (genvar i = 0; i < NB; i++) begin : g_rdl
    assign rd_v[8*i +: 8] = szl[i] ? shf_v[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_v;
  end

  assign rdata_o = rdata_q;
  assign sci_o   = ((|ren_q) && (|sts_q)) || ((|gps_q) && (|gpe_q));
endmodule

// File: rtl/pm_regblock_chk.sv
module pm_regblock_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [15:0]       event_i,
  input logic [15:0]       ev_q_i,
  input logic [15:0]       gps_i,
  input logic [31:0]       gpo_i,
  input logic [31:0]       gct_i,
  input logic [31:0]       tmr_i,
  input logic              power_off_i,
  input logic              hibernate_i,
  input logic              reboot_i
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({power_off_i, hibernate_i, reboot_i})); // R6
  AST_SLEEP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_off_i || hibernate_i) |-> $past(wr_i && (addr_i == ADDR_W'(4) || addr_i == ADDR_W'(5)))); // R6
  AST_REBOOT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_i |-> $past(wr_i && addr_i == ADDR_W'(8'h33) && wdata_i[7:0] == 8'h01)); // R7
  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_i == $past(tmr_i)) || (tmr_i == $past(tmr_i) + 32'd1)); // R11
  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(event_i & ~ev_q_i)) |=> ((gps_i & $past(event_i & ~ev_q_i)) == $past(event_i & ~ev_q_i))); // R10
  AST_GPO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpo_i[31]); // R5
  AST_GCT_B1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gct_i[1]); // R5
endmodule

bind pm_regblock pm_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .event_i(event_i), .ev_q_i(ev_q), .gps_i(gps_q), .gpo_i(gpo_q), .gct_i(gct_q),
  .tmr_i(tmr_cnt), .power_off_i(power_off_o), .hibernate_i(hibernate_o),
  .reboot_i(reboot_o)
);

// File: tb/pm_regblock_tb_top.sv
module pm_regblock_tb_top;
  localparam int CLK_HZ  = 100_000_000;
  localparam int TICK_HZ = 3_579_545;
  localparam int OVF_BIT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acpi = 1'b1;
  logic [5:0]  addr = '0;
  logic [2:0]  size = 3'd1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] ev = '0;
  logic        sci, poff, hib, rbt;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pm_regblock #(.ADDR_W(6), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .OVF_BIT(OVF_BIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acpi_mode_i(acpi), .addr_i(addr), .size_i(size),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .event_i(ev),
    .sci_o(sci), .power_off_o(poff), .hibernate_o(hib), .reboot_o(rbt)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_sts, m_ren, m_ctl, m_gps, m_gpe, m_prc, m_dst, m_gen, m_gct, m_dct, m_gpo;
  logic [31:0] m_tmr, m_rdata;
  logic [15:0] m_evp;
  longint      m_acc;
  logic        m_init, m_poff, m_hib, m_rbt;

  function automatic int base_of(input int a, output int w);
    w = 0;
    if (a < 2)                    begin w = 2; return 0;    end
    if (a < 4)                    begin w = 2; return 2;    end
    if (a < 6)                    begin w = 2; return 4;    end
    if (a >= 8  && a < 12)        begin w = 4; return 8;    end
    if (a >= 12 && a < 14)        begin w = 2; return 12;   end
    if (a >= 14 && a < 16)        begin w = 2; return 14;   end
    if (a >= 16 && a < 20)        begin w = 4; return 16;   end
    if (a >= 24 && a < 26)        begin w = 2; return 24;   end
    if (a >= 28 && a < 32)        begin w = 4; return 28;   end
    if (a >= 32 && a < 34)        begin w = 2; return 32;   end
    if (a >= 40 && a < 44)        begin w = 4; return 40;   end
    if (a >= 44 && a < 48)        begin w = 4; return 44;   end
    if (a == 51)                  begin w = 1; return 51;   end
    if (a >= 52 && a < 56)        begin w = 4; return 52;   end
    return -1;
  endfunction

  function automatic logic [31:0] m_read(input int a, input int sz);
    int w, b;
    logic [63:0] v;
    b = base_of(a, w);
    v = 0;
    case (b)
      0:  v = m_sts;  2: v = m_ren;  4: v = m_ctl;  8: v = m_tmr;
      12: v = m_gps; 14: v = m_gpe; 16: v = m_prc; 28: v = m_dst;
      32: v = m_gen; 40: v = m_gct; 44: v = m_dct; 52: v = m_gpo;
      24: v = ((m_gps != 0) ? 64'h80 : 64'h0) | (((m_sts & 32'hFFFE) != 0) ? 64'h40 : 64'h0)
            | ((m_dst != 0) ? 64'h10 : 64'h0);
      default: v = 0;
    endcase
    if (b >= 0) v = v >> (8 * (a - b));
    return 32'(v & ((64'd1 << (8 * sz)) - 1));
  endfunction

  function automatic void m_write(input int a, input int sz, input logic [31:0] d);
    int w, b, off;
    logic [31:0] bm, v;
    b = base_of(a, w);
    if (b < 0) return;
    off = a - b;
    bm = 0;
    for (int i = 0; i < 4; i++)
      if (i >= off && i < off + sz && i < w) bm[8*i +: 8] = 8'hFF;
    v = (d << (8 * off)) & bm;
    case (b)
      0:  m_sts = m_sts & ~v & 32'hFFFF;
      2:  m_ren = (m_ren & ~bm | v & 32'h0521) & 32'hFFFF;
      4:  begin
            m_ctl = (m_ctl & ~bm | v) & 32'hFFFF;
            if (v[13]) begin
              m_poff = (v[12:10] == 0);
              m_hib  = (v[12:10] == 1);
            end
          end
      12: m_gps = m_gps & ~v & 32'hFFFF;
      14: m_gpe = (m_gpe & ~bm | v & 32'h0F01) & 32'hFFFF;
      16: m_prc = m_prc & ~bm | v & 32'h00023E1E;
      28: m_dst = ~v;
      32: m_gen = (m_gen & ~bm | v & 32'h8D13) & 32'hFFFF;
      40: m_gct = m_gct & ~bm | v & 32'h0701FFE5;
      44: m_dct = m_dct & ~bm | v;
      51: m_rbt = (d[7:0] == 8'h01) && sz > 0;
      52: m_gpo = m_gpo & ~bm | v & 32'h7FFFFFFF;
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_ren = 0; m_ctl = 0; m_gps = 0; m_gpe = 0; m_prc = 0;
      m_dst = 0; m_gen = 0; m_gct = 0; m_dct = 0; m_gpo = 32'h7FFFBFFF;
      m_tmr = 0; m_acc = 0; m_rdata = 0; m_evp = 0; m_init = 1;
      m_poff = 0; m_hib = 0; m_rbt = 0;
    end else begin
      logic [31:0] old;
      if (rd) m_rdata = m_read(addr, size);
      m_poff = 0; m_hib = 0; m_rbt = 0;
      if (wr) m_write(addr, size, wdata);
      m_acc = m_acc + TICK_HZ;
      if (m_acc >= CLK_HZ) begin
        m_acc = m_acc - CLK_HZ;
        old = m_tmr;
        m_tmr = m_tmr + 1;
        if (old[OVF_BIT] != m_tmr[OVF_BIT]) m_sts = m_sts | 1;
      end
      m_gps = m_gps | (ev & ~m_evp);
      m_evp = ev;
      if (m_init && acpi) m_ctl = m_ctl | 1;
      m_init = 0;
    end
  end

  // ---------------- checks ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rdata vs model", rdata, m_rdata);
      chk("R9 sci vs model", {31'b0, sci},
          {31'b0, ((m_ren != 0) && (m_sts != 0)) || ((m_gps != 0) && (m_gpe != 0))});
      chk("R6 sleep pulses vs model", {30'b0, poff, hib}, {30'b0, m_poff, m_hib});
      chk("R7 reboot vs model", {31'b0, rbt}, {31'b0, m_rbt});
    end
  end

  task automatic rd_op(input int a, input int sz, output logic [31:0] d);
    addr = 6'(a); size = 3'(sz); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wr_op(input int a, input int sz, input logic [31:0] d, output logic [2:0] p);
    addr = 6'(a); size = 3'(sz); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    p = {poff, hib, rbt};
  endtask

  task automatic wr_rd(input string tag, input int a, input int sz, input logic [31:0] d,
                       input logic [31:0] exp);
    logic [2:0] p;
    logic [31:0] r;
    wr_op(a, sz, d, p);
    rd_op(a, sz, r);
    chk(tag, r, exp);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, t0;
    logic [2:0]  p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values and holes
    rd_op(8'h04, 2, r); chk("R1 ctl bit0 after reset", r, 32'h1);
    rd_op(8'h34, 4, r); chk("R1 gpo reset", r, 32'h7FFFBFFF);
    rd_op(8'h00, 2, r); chk("R1 status reset", r, 32'h0);
    rd_op(8'h14, 1, r); chk("R1 hole 0x14", r, 32'h0);
    rd_op(8'h30, 1, r); chk("R1 hole 0x30", r, 32'h0);
    rd_op(8'h06, 2, r); chk("R1 hole 0x06", r, 32'h0);

    // R4 writable masks
    wr_rd("R4 resume enable mask", 8'h02, 2, 32'hFFFF, 32'h0521);
    wr_rd("R4 gp enable mask", 8'h0E, 2, 32'hFFFF, 32'h0F01);
    wr_rd("R4 proc ctl mask", 8'h10, 4, 32'hFFFFFFFF, 32'h00023E1E);
    wr_rd("R4 global enable mask", 8'h20, 2, 32'hFFFF, 32'h8D13);
    wr_op(8'h02, 2, 32'h0, p);

    // R5 forced bits
    wr_rd("R5 global ctl bit1", 8'h28, 4, 32'hFFFFFFFF, 32'h0701FFE5);
    wr_op(8'h37, 1, 32'h00, p);
    rd_op(8'h34, 4, r); chk("R5 gpo top byte cleared", r, 32'h00FFBFFF);
    wr_op(8'h37, 1, 32'hFF, p);
    rd_op(8'h34, 4, r); chk("R5 gpo bit31 never set", r, 32'h7FFFBFFF);

    // R2 byte lanes
    wr_op(8'h2C, 4, 32'h11223344, p);
    wr_op(8'h2D, 1, 32'hFFFF_FFAA, p);
    rd_op(8'h2C, 4, r); chk("R2 byte write at +1", r, 32'h1122AA44);
    rd_op(8'h2E, 2, r); chk("R2 half read at +2", r, 32'h1122);
    rd_op(8'h2F, 1, r); chk("R2 byte read at +3", r, 32'h11);
    rd_op(8'h2C, 1, r); chk("R2 size-1 upper zero", r, 32'h44);
    wr_op(8'h2E, 2, 32'hFFFF5566, p);
    rd_op(8'h2C, 4, r); chk("R2 half write covers two lanes", r, 32'h5566AA44);

    // R6 sleep decode
    wr_op(8'h04, 2, 32'h2001, p); chk("R6 type0 power-off", {29'b0, p}, 32'h4);
    wr_op(8'h04, 2, 32'h2401, p); chk("R6 type1 hibernate", {29'b0, p}, 32'h2);
    wr_op(8'h04, 2, 32'h3401, p); chk("R6 type5 no pulse", {29'b0, p}, 32'h0);
    rd_op(8'h04, 2, r);           chk("R6 stored bits", r, 32'h3401);
    wr_op(8'h05, 1, 32'h24, p);   chk("R6 byte write hibernate", {29'b0, p}, 32'h2);
    @(negedge clk);
    chk("R6 pulse lasts one cycle", {31'b0, hib}, 32'h0);

    // R7 reset register
    wr_op(8'h33, 1, 32'h01, p); chk("R7 key reboots", {29'b0, p}, 32'h1);
    wr_op(8'h33, 1, 32'h02, p); chk("R7 other value ignored", {29'b0, p}, 32'h0);
    wr_op(8'h33, 1, 32'hFF, p); chk("R7 0xFF ignored", {29'b0, p}, 32'h0);

    // R10 R9 R8 R3 events
    ev[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd_op(8'h0C, 2, r); chk("R10 rising edge sets gps", r, 32'h0008);
    chk("R9 sci from gp pair", {31'b0, sci}, 32'h1);
    rd_op(8'h18, 2, r); chk("R8 summary gp bit7", r, 32'h0080);
    wr_op(8'h0C, 2, 32'h0008, p);
    rd_op(8'h0C, 2, r); chk("R3 w1c gps / R10 held level", r, 32'h0);
    chk("R9 sci drops", {31'b0, sci}, 32'h0);
    ev[3] = 1'b0; @(negedge clk);
    ev[3] = 1'b1; ev[9] = 1'b1; @(negedge clk);
    rd_op(8'h0C, 2, r); chk("R10 second edge", r, 32'h0208);
    wr_op(8'h0C, 2, 32'h0200, p);
    rd_op(8'h0C, 2, r); chk("R3 w0 keeps bit", r, 32'h0008);
    wr_op(8'h0E, 2, 32'h0, p);
    @(negedge clk);
    chk("R9 sci needs enable", {31'b0, sci}, 32'h0);
    wr_op(8'h0C, 2, 32'hFFFF, p);

    // R12 device status and R8 bit4
    wr_op(8'h1C, 4, 32'h0, p);
    rd_op(8'h1C, 4, r); chk("R12 complement of zero", r, 32'hFFFFFFFF);
    rd_op(8'h18, 2, r); chk("R8 summary device bit4", r, 32'h0010);
    wr_op(8'h1E, 1, 32'h0F, p);
    rd_op(8'h1C, 4, r); chk("R12 shifted complement", r, 32'hFFF0FFFF);
    wr_op(8'h1C, 4, 32'hFFFFFFFF, p);
    rd_op(8'h18, 2, r); chk("R8 summary clear", r, 32'h0);

    // R11 timer
    wr_op(8'h08, 4, 32'h0, p);
    rd_op(8'h08, 4, t0);
    repeat (10000) @(negedge clk);
    rd_op(8'h08, 4, r);
    chk("R11 timer rate", {31'b0, ((r - t0) == 357) || ((r - t0) == 358)}, 32'h1);
    rd_op(8'h00, 2, r); chk("R11 overflow sets status0", r & 32'h1, 32'h1);
    rd_op(8'h18, 2, r); chk("R8 status bit0 not summarised", r, 32'h0);
    wr_op(8'h02, 2, 32'h0001, p);
    @(negedge clk);
    chk("R9 sci from status pair", {31'b0, sci}, 32'h1);
    wr_op(8'h00, 2, 32'hFFFF, p);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule